// File: doc/BRIEF.md
# Pipelined Dual Ones-Complement Checksum Accumulator

This block sums a stream of 32-bit words into a 32-bit register. The register holds two separate 16-bit ones-complement running sums: the upper half collects the high halfwords and the lower half collects the low halfwords. A host folds the two halves and inverts the result to get a network checksum. That final step is outside this block.

Each 16-bit half is cut into six short carry-lookahead groups. The carry out of each group goes into a register and enters the next group up on the following clock. The top group's carry wraps back to bit 0 of the same half, so the carries circulate in a ring. This keeps the logic depth per clock at one short group, whatever the word width. On clocks without an add, zero is summed, which lets the pending carries drain. A settled flag and an idle-clock counter tell the host when the sum is final. There is no load port. A start value is applied by clearing the block and then adding that value as an ordinary word.

Top module: `csum_ring_acc`

## Requirements
- R1: No carry crosses between bits 15..0 and bits 31..16. A carry out of bit 15 wraps to bit 0, and a carry out of bit 31 wraps to bit 16.
- R2: Once settled, each half equals the ones-complement sum, with end-around carry, of the halfwords added into it since the last clear. The lower half sums data bits 15..0 and the upper half sums bits 31..16.
- R3: Each half is split, from bit 0 up, into lookahead groups of 3, 3, 2, 3, 3 and 2 bits. A group's carry out is registered and enters the next group one clock later. For example, adding 1 to a lower half holding 7 gives 0 on that clock and 8 on the next.
- R4: A clear (`clr` high at a clock edge) zeroes the sum, every carry register, the input latch and the pending add. An add that follows without a capture therefore adds zero.
- R5: On a clock where no add is pending, zero is summed. Pending carries keep moving, and a settled sum stays unchanged.
- R6: When `cap` and `add_en` are high together at an edge, the word on `din` is latched at that edge and summed at the next edge. One word can be accepted every clock.
- R7: `cap` alone updates the latch but leaves the sum unchanged. `add_en` alone sums the word already in the latch.
- R8: `settled` is high exactly when no carry is pending and no add is pending. After the last add, it rises within 13 clocks.
- R9: `idle_cnt` is 0 on the clock that performs an add. It then rises by one per clock with no add, and stops at 15. A clear sets it to 0.
- R10: A start value is applied by clearing the block and then adding the value as an ordinary word. Later words are summed on top of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the sum, carries, latch and pending add |
| cap | input | 1 | Latch `din` at this edge |
| add_en | input | 1 | Sum the latched word at the next edge |
| din | input | 32 | Input data word |
| sum_q | output | 32 | Two 16-bit partial sums (high and low) |
| settled | output | 1 | No carry and no add pending |
| idle_cnt | output | 4 | Clocks since the last add, stopping at 15 |

## Verification
The hardest case to reach from the ports is a carry that must travel around the whole ring. This needs a half to hold all ones in several groups at once while a carry is still pending. The stimulus builds this with all-ones words and with a low-half value of 0xFFFF followed by a 1. The same words also check that nothing leaks into the upper half. A short sequence of 7 then 1 shows the carry passing between groups one clock at a time. Pseudo-random bursts compare the settled result with a model that sums the two halfword streams separately, each with end-around carry.

// File: rtl/csum_pkg.sv
package csum_pkg;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned NHALF  = 2;
  localparam int unsigned DATA_W = HALF_W * NHALF;
  localparam int unsigned NGRP   = 6;
  localparam int unsigned NCY    = NGRP * NHALF;
  localparam int unsigned IDLE_W = 4;

  // width of lookahead group g (3,3,2,3,3,2 from bit 0 upward)
  function automatic int unsigned grp_w(int unsigned g);
    case (g)
      2, 5:    return 2;
      default: return 3;
    endcase
  endfunction

  // lowest bit of lookahead group g
  function automatic int unsigned grp_lo(int unsigned g);
    int unsigned s;
    s = 0;
    for (int unsigned k = 0; k < g; k++) s += grp_w(k);
    return s;
  endfunction
endpackage

// File: rtl/csum_group.sv
module csum_group #(
  parameter int unsigned W = 3
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  logic [W:0]   c;
  logic [W-1:0] gen;
  logic [W-1:0] prp;

  always_comb begin
    gen  = a & b;
    prp  = a | b;
    c[0] = cin;
    for (int k = 0; k < int'(W); k++) c[k+1] = gen[k] | (prp[k] & c[k]);
    s    = a ^ b ^ c[W-1:0];
    cout = c[W];
  end
endmodule

// File: rtl/csum_half.sv
module csum_half
  import csum_pkg::*;
#(
  parameter int unsigned HW = HALF_W,
  parameter int unsigned NG = NGRP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [HW-1:0] addend,
  output logic [HW-1:0] sum,
  output logic [NG-1:0] carry
);
  logic [HW-1:0] sum_q, sum_d, sum_nxt;
  logic [NG-1:0] cy_q, cy_d, cy_nxt;

  for (genvar g = 0; g < int'(NG); g++) begin : g_grp
    localparam int unsigned LO   = grp_lo(g);
    localparam int unsigned GW   = grp_w(g);
    localparam int unsigned PREV = (g + NG - 1) % NG;
    csum_group #(.W(GW)) grp_i (
      .a   (sum_q[LO +: GW]),
      .b   (addend[LO +: GW]),
      .cin (cy_q[PREV]),
      .s   (sum_d[LO +: GW]),
      .cout(cy_d[g])
    );
  end

  always_comb begin
    sum_nxt = clr ? '0 : sum_d;
    cy_nxt  = clr ? '0 : cy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      cy_q  <= '0;
    end else begin
      sum_q <= sum_nxt;
      cy_q  <= cy_nxt;
    end
  end

  assign sum   = sum_q;
  assign carry = cy_q;
endmodule

// File: rtl/csum_in_stage.sv
module csum_in_stage
  import csum_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cap,
  input  logic          add_en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dl_q,
  output logic          add_q
);
  logic [DW-1:0] dl_nxt;
  logic          dl_en;
  logic          add_nxt;

  always_comb begin
    dl_en   = clr | cap;
    dl_nxt  = clr ? '0 : din;
    add_nxt = ~clr & add_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_q  <= '0;
      add_q <= 1'b0;
    end else begin
      if (dl_en) dl_q <= dl_nxt;
      add_q <= add_nxt;
    end
  end
endmodule

// File: rtl/csum_idle_mon.sv
module csum_idle_mon
  import csum_pkg::*;
#(
  parameter int unsigned IW = IDLE_W,
  parameter int unsigned NC = NCY
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add_q,
  input  logic [NC-1:0] carry_all,
  output logic          settled,
  output logic [IW-1:0] idle_cnt
);
  localparam logic [IW-1:0] CNT_MAX = '1;
  logic [IW-1:0] cnt_q, cnt_nxt;
  logic          cnt_en;

  always_comb begin
    cnt_en  = clr | add_q | (cnt_q != CNT_MAX);
    cnt_nxt = (clr | add_q) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign settled  = ~add_q & ~(|carry_all);
  assign idle_cnt = cnt_q;
endmodule

// File: rtl/csum_ring_acc.sv
module csum_ring_acc
  import csum_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap,
  input  logic              add_en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] sum_q,
  output logic              settled,
  output logic [IDLE_W-1:0] idle_cnt
);
  logic [DATA_W-1:0] dl_q;
  logic              add_q;
  logic [DATA_W-1:0] addend;
  logic [NCY-1:0]    carry_all;

  csum_in_stage #(.DW(DATA_W)) in_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .cap   (cap),
    .add_en(add_en),
    .din   (din),
    .dl_q  (dl_q),
    .add_q (add_q)
  );

  assign addend = add_q ? dl_q : '0;

  for (genvar h = 0; h < int'(NHALF); h++) begin : g_half
    csum_half #(.HW(HALF_W), .NG(NGRP)) half_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .addend(addend[h*HALF_W +: HALF_W]),
      .sum   (sum_q[h*HALF_W +: HALF_W]),
      .carry (carry_all[h*NGRP +: NGRP])
    );
  end

  csum_idle_mon #(.IW(IDLE_W), .NC(NCY)) mon_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .add_q    (add_q),
    .carry_all(carry_all),
    .settled  (settled),
    .idle_cnt (idle_cnt)
  );
endmodule

// File: rtl/csum_ring_acc_chk.sv
module csum_ring_acc_chk
  import csum_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              cap,
  input logic              add_en,
  input logic [DATA_W-1:0] sum_q,
  input logic              settled,
  input logic [IDLE_W-1:0] idle_cnt,
  input logic [DATA_W-1:0] dl_q,
  input logic              add_q,
  input logic [NCY-1:0]    carry_all
);
  assert_clear_zeroes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sum_q == '0) && settled && (dl_q == '0));

  assert_settled_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !add_en && !clr) |=> ($stable(sum_q) && settled));

  assert_latch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !cap) |=> $stable(dl_q));

  assert_low_isolated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (carry_all[NGRP-1:0] == '0) && (!add_q || dl_q[HALF_W-1:0] == '0))
      |=> $stable(sum_q[HALF_W-1:0]));

  assert_idle_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !add_q && idle_cnt != '1) |=> (idle_cnt == $past(idle_cnt) + 1'b1));

  assert_idle_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    add_q |=> (idle_cnt == '0));
endmodule

bind csum_ring_acc csum_ring_acc_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr      (clr),
  .cap      (cap),
  .add_en   (add_en),
  .sum_q    (sum_q),
  .settled  (settled),
  .idle_cnt (idle_cnt),
  .dl_q     (dl_q),
  .add_q    (add_q),
  .carry_all(carry_all)
);

// File: tb/csum_ring_acc_tb_top.sv
module csum_ring_acc_tb_top;
  logic        clk;
  logic        rst_n;
  logic        clr;
  logic        cap;
  logic        add_en;
  logic [31:0] din;
  logic [31:0] sum_q;
  logic        settled;
  logic [3:0]  idle_cnt;

  int unsigned total;
  int unsigned bad;
  bit          done;
  logic [15:0] m_lo, m_hi;
  logic [31:0] rng;
  logic [31:0] exp_q[$];

  csum_ring_acc dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cap(cap), .add_en(add_en),
    .din(din), .sum_q(sum_q), .settled(settled), .idle_cnt(idle_cnt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] fold(logic [15:0] a, logic [15:0] b);
    logic [16:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[15:0] + {15'd0, t[16]};
  endfunction

  function automatic logic [31:0] next_rng(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic model_add(logic [31:0] w);
    m_lo = fold(m_lo, w[15:0]);
    m_hi = fold(m_hi, w[31:16]);
  endtask

  task automatic do_clear();
    clr = 1'b1; cap = 1'b0; add_en = 1'b0;
    @(negedge clk);
    clr = 1'b0;
    m_lo = '0; m_hi = '0;
  endtask

  task automatic push_word(logic [31:0] w);
    din = w; cap = 1'b1; add_en = 1'b1;
    @(negedge clk);
    model_add(w);
  endtask

  task automatic go_idle();
    cap = 1'b0; add_en = 1'b0;
  endtask

  // hand the expected result to the monitor and wait for it to be compared
  task automatic expect_sum();
    go_idle();
    exp_q.push_back({m_hi, m_lo});
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor: waits for settled, then compares against the queued item
  initial begin
    forever begin
      wait (exp_q.size() > 0);
      begin
        int lat;
        logic [31:0] e;
        lat = 0;
        e = exp_q[0];
        while (lat < 20) begin
          @(negedge clk);
          lat++;
          if (settled) break;
        end
        chk(lat <= 13, "R8 settle latency", lat, 13);
        chk(sum_q == e, "R2 settled sum", sum_q, e);
        chk(sum_q[15:0] == e[15:0] && sum_q[31:16] == e[31:16],
            "R1 halves independent", sum_q, e);
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 0;
    rst_n = 1'b0; clr = 1'b0; cap = 1'b0; add_en = 1'b0; din = '0;
    m_lo = '0; m_hi = '0; rng = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R4)
    chk(sum_q == 32'h0, "R4 reset sum", sum_q, 0);
    chk(settled == 1'b1, "R8 reset settled", settled, 1);

    // R3: group carry moves one group per clock
    do_clear();
    push_word(32'h0000_0007);
    push_word(32'h0000_0001);
    chk(sum_q == 32'h0000_0007, "R6 first word summed one edge after capture", sum_q, 7);
    go_idle();
    @(negedge clk);
    chk(sum_q == 32'h0000_0000, "R3 group0 wraps, carry pending", sum_q, 0);
    chk(settled == 1'b0, "R8 carry pending not settled", settled, 0);
    @(negedge clk);
    chk(sum_q == 32'h0000_0008, "R3 carry lands in group1", sum_q, 8);
    expect_sum();

    // R1: low half wraps at bit 15 into bit 0 only
    do_clear();
    push_word(32'h0000_FFFF);
    push_word(32'h0000_0001);
    expect_sum();
    chk(sum_q == 32'h0000_0001, "R1 end-around low, high untouched", sum_q, 32'h1);

    // R2: all-ones stream, full-ring carries
    do_clear();
    for (int i = 0; i < 5; i++) push_word(32'hFFFF_FFFF);
    expect_sum();
    do_clear();
    push_word(32'h8001_FFFF);
    push_word(32'hFFFF_8001);
    push_word(32'h7FFF_0001);
    expect_sum();

    // R2 / R6: pseudo-random back-to-back bursts
    for (int b = 0; b < 6; b++) begin
      do_clear();
      for (int i = 0; i < 10 + 7 * b; i++) begin
        rng = next_rng(rng);
        push_word(rng);
      end
      expect_sum();
    end

    // R7: capture alone leaves sum; add alone re-adds latch
    begin
      logic [31:0] held;
      held = sum_q;
      din = 32'h0123_4567; cap = 1'b1; add_en = 1'b0;
      repeat (3) @(negedge clk);
      chk(sum_q == held, "R7 capture without add", sum_q, held);
      cap = 1'b0; add_en = 1'b1;
      @(negedge clk);
      model_add(32'h0123_4567);
      expect_sum();
    end

    // R5: idle clocks leave a settled sum unchanged
    begin
      logic [31:0] held;
      held = sum_q;
      repeat (6) @(negedge clk);
      chk(sum_q == held, "R5 idle keeps sum", sum_q, held);
    end

    // R4: clear with carries pending also empties the latch
    do_clear();
    for (int i = 0; i < 4; i++) push_word(32'hFFFF_FFFF);
    do_clear();
    chk(sum_q == 32'h0, "R4 clear mid-flight", sum_q, 0);
    add_en = 1'b1; cap = 1'b0;
    @(negedge clk);
    add_en = 1'b0;
    repeat (8) @(negedge clk);
    chk(sum_q == 32'h0, "R4 latch cleared, add sums zero", sum_q, 0);

    // R10: start value by clear then ordinary add
    do_clear();
    push_word(32'hABCD_1234);
    chk(sum_q == 32'h0, "R10 start value not yet summed", sum_q, 0);
    push_word(32'h5555_F00F);
    push_word(32'h0F0F_FFF0);
    expect_sum();

    // R9: idle counter
    do_clear();
    push_word(32'h0000_0003);
    go_idle();
    @(negedge clk);
    chk(idle_cnt == 4'd0, "R9 zero on add clock", idle_cnt, 0);
    repeat (3) @(negedge clk);
    chk(idle_cnt == 4'd3, "R9 counts idle clocks", idle_cnt, 3);
    repeat (20) @(negedge clk);
    chk(idle_cnt == 4'd15, "R9 stops at max", idle_cnt, 15);
    do_clear();
    chk(idle_cnt == 4'd0, "R9 clear zeroes counter", idle_cnt, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule